// File: doc/BRIEF.md
# Serial Microport Register Interface

This block is the slave end of a synchronous serial port through which a host microcontroller reads and writes a bank of 32 byte-wide registers. Each session is framed by an active-low chip select and carries exactly two bytes. A command byte comes first and gives the direction and the register address. A data byte follows and is either written into that register or read back from it. Bits travel least significant first. Both the sampling of incoming bits and the driving of outgoing bits happen on the falling serial clock edge.

Chip select, serial clock and incoming data are oversampled by the block's own clock through a short synchronizer, so every serial event acts a fixed few system cycles after the pin event. The data path uses one bidirectional primary pin by default. A mode bit in the control register moves transmission onto a secondary pin and leaves the primary pin as receive-only. An open-drain interrupt output is pulled low while any latched, unmasked event bit is set in the status register. Reading that register in a complete session releases it.

Top module: `serial_microport`

## Requirements
- R1: A session starts when chip select goes low. The first 8 falling serial clock edges shift in the command byte and the next 8 shift the data byte. Further falling edges before chip select rises have no effect.
- R2: Command byte: bit 0 is received first and is the direction flag (1 = read, 0 = write). Bits 1 to 5 hold the register address. Bits 6 and 7 are ignored.
- R3: Data moves least significant bit first in both directions. The first data bit received is stored as register bit 0.
- R4: On a read, the addressed register is captured after the 8th falling edge. Register bit k is driven on the data output following falling edge 9+k and holds until the next falling edge.
- R5: Neither output enable is active while chip select is high. In normal mode the primary enable is active only during the data phase of a read, from the 9th falling edge until chip select rises.
- R6: Bit 0 of the control register at address 0x0F selects split mode. In split mode the primary pin only receives, the primary enable stays off, and the secondary pin transmits with its enable active whenever chip select is low.
- R7: If chip select rises before the 16th falling edge, the session is abandoned. No register is written and the status register is not cleared.
- R8: Status register 0x10 bit i is set when event input bit i is high while mask register 0x11 bit i is set. The interrupt output (1 = pin pulled low) is active while any status bit is set.
- R9: A complete read session of the status register clears it and releases the interrupt, unless a new unmasked event arrives. Writes to the status register are ignored.
- R10: Writing the control register with bit 7 set returns every register, including the mode bit and the status, to zero.
- R11: After hardware reset all registers read zero, both output enables are off and the interrupt is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| pri_in | input | 1 | Primary data pin, input side |
| pri_out | output | 1 | Primary data pin, output value |
| pri_oe | output | 1 | Primary data pin output enable |
| sec_out | output | 1 | Secondary data pin, output value |
| sec_oe | output | 1 | Secondary data pin output enable |
| irq_od_en | output | 1 | Open-drain interrupt; 1 pulls the pin low |
| evt_in | input | 8 | Event stimulus, one bit per status bit |

## Verification
A pin event reaches the logic after two synchronizer stages plus one edge register, so each serial action lands about three system cycles after the host edge. The bench holds each serial clock phase for eight system cycles. It samples the output data and enables eight cycles after each falling edge and changes input data only at rising edges. The interrupt is checked three cycles after an event pulse, and register effects are checked only through later complete sessions. The enable check at the 16th bit is skipped because a software reset written there lawfully changes the mode before chip select rises.

// File: rtl/mp_pkg.sv
// Shared constants and types for the serial microport.
// Assumes a 32-entry byte-wide register bank; fixed addresses are listed here.
package mp_pkg;
    localparam int DW      = 8;
    localparam int AW      = 5;
    localparam int NREG    = 1 << AW;
    localparam int CNT_W   = $clog2(2 * DW + 1);

    localparam logic [AW-1:0] CTRL_ADDR = 5'h0F;
    localparam logic [AW-1:0] STAT_ADDR = 5'h10;
    localparam logic [AW-1:0] MASK_ADDR = 5'h11;

    localparam int SPLIT_BIT = 0;
    localparam int SWRST_BIT = 7;

    // Command byte, bit 0 is the first bit on the wire.
    typedef struct packed {
        logic [1:0]    spare;
        logic [AW-1:0] addr;
        logic          rd;
    } cmd_t;
endpackage

// File: rtl/mp_sync.sv
// Multi-stage synchronizer with falling-edge detect for a group of pins.
// Assumes all inputs are slow compared with clk; all bits share one latency.
module mp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Move the pin values one stage deeper each cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '1;
                else if (g == 0) stg[g] <= d;
                else stg[g] <= stg[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    // Hold the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else prev_q <= stg[STAGES-1];
    end

    assign q    = stg[STAGES-1];
    assign fall = prev_q & ~stg[STAGES-1];
endmodule

// File: rtl/mp_shifter.sv
// Session engine: counts falling serial edges, assembles the command and
// data bytes LSB first, shifts read data out and issues completion strobes.
// Assumes synchronized inputs; strobes fire only on the 16th edge.
module mp_shifter
    import mp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_low,
    input  logic          edge_fall,
    input  logic          din,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] addr,
    output logic          wr_stb,
    output logic          rd_done,
    output logic [DW-1:0] wr_data,
    output logic          tx_bit,
    output logic          active,
    output logic          rd_phase,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(DW - 1);
    localparam logic [CNT_W-1:0] DAT_FIRST = CNT_W'(DW);
    localparam logic [CNT_W-1:0] ALL_LAST = CNT_W'(2 * DW - 1);
    localparam logic [CNT_W-1:0] ALL_DONE = CNT_W'(2 * DW);

    cmd_t          cmd_q;
    logic [DW-1:0] dat_q;
    logic [DW-1:0] tx_sh;
    logic          ld_q;
    logic          take;

    assign take = cs_low && edge_fall && (bit_cnt != ALL_DONE);
    assign addr = cmd_q.addr;

    // Track the session, shift bytes in and shift read data out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            bit_cnt  <= '0;
            rd_phase <= 1'b0;
            cmd_q    <= '0;
            dat_q    <= '0;
            tx_sh    <= '0;
            tx_bit   <= 1'b0;
        end else if (!cs_low) begin
            active   <= 1'b0;
            bit_cnt  <= '0;
            rd_phase <= 1'b0;
        end else begin
            active <= 1'b1;
            if (take) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt <= CMD_LAST) begin
                    cmd_q <= {din, cmd_q[DW-1:1]};
                end else begin
                    dat_q  <= {din, dat_q[DW-1:1]};
                    tx_bit <= tx_sh[0];
                    tx_sh  <= tx_sh >> 1;
                    if (bit_cnt == DAT_FIRST) rd_phase <= cmd_q.rd;
                end
            end else if (ld_q) begin
                tx_sh <= rd_data;
            end
        end
    end

    // Raise the load request after the 8th edge and the completion strobes on the 16th.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q    <= 1'b0;
            wr_stb  <= 1'b0;
            rd_done <= 1'b0;
            wr_data <= '0;
        end else begin
            ld_q    <= take && (bit_cnt == CMD_LAST);
            wr_stb  <= take && (bit_cnt == ALL_LAST) && !cmd_q.rd;
            rd_done <= take && (bit_cnt == ALL_LAST) && cmd_q.rd;
            if (take && (bit_cnt == ALL_LAST)) wr_data <= {din, dat_q[DW-1:1]};
        end
    end
endmodule

// File: rtl/mp_regbank.sv
// Register bank: plain storage, control (split mode, software reset),
// event mask and a sticky status register that a read clears.
// Assumes at most one write or read completion per cycle.
module mp_regbank
    import mp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_stb,
    input  logic          rd_done,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] evt_in,
    output logic [DW-1:0] rd_data,
    output logic          split,
    output logic          irq,
    output logic          stat_clr,
    output logic          sw_rst,
    output logic [DW-1:0] evt_hit
);
    logic [DW-1:0] regs [NREG];

    assign sw_rst   = wr_stb && (addr == CTRL_ADDR) && wr_data[SWRST_BIT];
    assign stat_clr = rd_done && (addr == STAT_ADDR);
    assign evt_hit  = evt_in & regs[MASK_ADDR];

    // Update storage; status collects masked events and clears on a completed read.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            if (wr_stb && (addr != STAT_ADDR)) regs[addr] <= wr_data;
            regs[STAT_ADDR] <= (regs[STAT_ADDR] & ~{DW{stat_clr}}) | evt_hit;
        end
    end

    assign rd_data = regs[addr];
    assign split   = regs[CTRL_ADDR][SPLIT_BIT];
    assign irq     = |regs[STAT_ADDR];
endmodule

// File: rtl/serial_microport.sv
// Top of the serial microport: synchronizes the pins, runs the session
// engine against the register bank and steers data onto the pins.
// Assumes the host serial clock is well below clk/4.
module serial_microport
    import mp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          pri_in,
    output logic          pri_out,
    output logic          pri_oe,
    output logic          sec_out,
    output logic          sec_oe,
    output logic          irq_od_en,
    input  logic [DW-1:0] evt_in
);
    logic [2:0]       pins_q;
    logic [2:0]       pins_fall;
    logic [AW-1:0]    addr;
    logic             wr_stb;
    logic             rd_done;
    logic [DW-1:0]    wr_data;
    logic [DW-1:0]    rd_data;
    logic             tx_bit;
    logic             active;
    logic             rd_phase;
    logic [CNT_W-1:0] bit_cnt;
    logic             split;
    logic             stat_clr;
    logic             sw_rst;
    logic [DW-1:0]    evt_hit;

    mp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, sclk, pri_in}),
        .q    (pins_q),
        .fall (pins_fall)
    );

    mp_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_low   (!pins_q[2]),
        .edge_fall(pins_fall[1]),
        .din      (pins_q[0]),
        .rd_data  (rd_data),
        .addr     (addr),
        .wr_stb   (wr_stb),
        .rd_done  (rd_done),
        .wr_data  (wr_data),
        .tx_bit   (tx_bit),
        .active   (active),
        .rd_phase (rd_phase),
        .bit_cnt  (bit_cnt)
    );

    mp_regbank u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_stb  (wr_stb),
        .rd_done (rd_done),
        .wr_data (wr_data),
        .evt_in  (evt_in),
        .rd_data (rd_data),
        .split   (split),
        .irq     (irq_od_en),
        .stat_clr(stat_clr),
        .sw_rst  (sw_rst),
        .evt_hit (evt_hit)
    );

    assign pri_out = tx_bit;
    assign sec_out = tx_bit;
    assign pri_oe  = active && rd_phase && !split;
    assign sec_oe  = active && split;
endmodule

// File: rtl/mp_checker.sv
// Property checker for the serial microport, attached by bind.
// Assumes the internal names of serial_microport listed in the bind below.
module mp_checker
    import mp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             pri_oe,
    input logic             sec_oe,
    input logic             irq_od_en,
    input logic             split,
    input logic             stat_clr,
    input logic             sw_rst,
    input logic [DW-1:0]    evt_hit,
    input logic [CNT_W-1:0] bit_cnt
);
    // R5: a settled high chip select leaves both drivers off.
    p_idle_tristate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)
        |-> !pri_oe && !sec_oe);

    // R6: in split mode the primary pin never drives.
    p_split_pri_r6: assert property (@(posedge clk) disable iff (!rst_n)
        split |-> !pri_oe);

    // R6: in normal mode the secondary pin never drives.
    p_normal_sec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !split |-> !sec_oe);

    // R8: the interrupt holds until a status read or a software reset.
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_od_en && !stat_clr && !sw_rst |=> irq_od_en);

    // R9: a status read with no new event releases the interrupt.
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr && (evt_hit == '0) |=> !irq_od_en);

    // R10: a software reset leaves normal mode and no interrupt.
    p_swrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> !split && !irq_od_en);

    // R1: the edge count never passes the two-byte length.
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(2 * DW));
endmodule

bind serial_microport mp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .pri_oe   (pri_oe),
    .sec_oe   (sec_oe),
    .irq_od_en(irq_od_en),
    .split    (split),
    .stat_clr (stat_clr),
    .sw_rst   (sw_rst),
    .evt_hit  (evt_hit),
    .bit_cnt  (bit_cnt)
);

// File: tb/sim_serial_microport.sv
// Bench: sweeps the register bank through full sessions and exercises
// abort, interrupt, split mode and software reset.
module sim_serial_microport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b1;
    logic       pri_in = 1'b0;
    logic       pri_out, pri_oe, sec_out, sec_oe, irq_od_en;
    logic [7:0] evt_in = 8'h00;

    int vectors = 0;
    int errors = 0;

    always #5 clk = ~clk;

    serial_microport u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .pri_in(pri_in),
        .pri_out(pri_out), .pri_oe(pri_oe), .sec_out(sec_out), .sec_oe(sec_oe),
        .irq_od_en(irq_od_en), .evt_in(evt_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One session; nbits < 16 abandons it early. Checks the enables per bit.
    task automatic xfer(input logic rd, input logic [4:0] a, input logic [1:0] spare,
                        input logic [7:0] wd, input int nbits, input logic split,
                        output logic [7:0] rv);
        logic [7:0] cmd;
        cmd = {spare, a, rd};
        rv = 8'h00;
        cs_n = 1'b0;
        waitn(8);
        for (int i = 0; i < nbits; i++) begin
            pri_in = (i < 8) ? cmd[i] : wd[i-8];
            waitn(4);
            sclk = 1'b0;
            waitn(8);
            if (i < 15) begin
                chk("R5 pri_oe", pri_oe, (!split && rd && i >= 8));
                chk("R6 sec_oe", sec_oe, split);
            end
            if (i >= 8) rv[i-8] = split ? sec_out : pri_out;
            sclk = 1'b1;
            waitn(4);
        end
        waitn(8);
        cs_n = 1'b1;
        waitn(8);
        chk("R5 idle enables", {pri_oe, sec_oe}, 2'b00);
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7) ^ (a << 5));
    endfunction

    task automatic pulse(input logic [7:0] v);
        evt_in = v;
        waitn(1);
        evt_in = 8'h00;
        waitn(3);
    endtask

    initial begin
        logic [7:0] rv;
        waitn(5);
        rst_n = 1'b1;
        waitn(2);
        chk("R11 reset enables", {pri_oe, sec_oe}, 2'b00);
        chk("R11 reset irq", irq_od_en, 1'b0);
        xfer(1'b1, 5'h0F, 2'b00, 8'h00, 16, 1'b0, rv);
        chk("R11 ctrl after reset", rv, 8'h00);
        xfer(1'b1, 5'h05, 2'b00, 8'h00, 16, 1'b0, rv);
        chk("R11 reg after reset", rv, 8'h00);

        // R1 R2 R3 R4: write every plain register, spare bits varied, read back.
        for (int a = 0; a < 32; a++) begin
            if (a == 15 || a == 16) continue;
            xfer(1'b0, 5'(a), 2'(a), pat(a), 16, 1'b0, rv);
        end
        for (int a = 0; a < 32; a++) begin
            if (a == 15 || a == 16) continue;
            xfer(1'b1, 5'(a), ~2'(a), 8'h00, 16, 1'b0, rv);
            chk("R1 R2 R3 R4 readback", rv, pat(a));
        end
        // R3: single-bit values pin down the bit order.
        xfer(1'b0, 5'h01, 2'b00, 8'h80, 16, 1'b0, rv);
        xfer(1'b1, 5'h01, 2'b00, 8'h00, 16, 1'b0, rv);
        chk("R3 msb only", rv, 8'h80);
        xfer(1'b0, 5'h02, 2'b00, 8'h01, 16, 1'b0, rv);
        xfer(1'b1, 5'h02, 2'b00, 8'h00, 16, 1'b0, rv);
        chk("R3 lsb only", rv, 8'h01);

        // R7: abandoned writes leave the register alone.
        xfer(1'b0, 5'h03, 2'b00, 8'hAA, 16, 1'b0, rv);
        xfer(1'b0, 5'h03, 2'b00, 8'h55, 12, 1'b0, rv);
        xfer(1'b0, 5'h03, 2'b00, 8'h55, 15, 1'b0, rv);
        xfer(1'b1, 5'h03, 2'b00, 8'h00, 16, 1'b0, rv);
        chk("R7 abort write", rv, 8'hAA);

        // R8 R9 R7: masked events, sticky interrupt, clear on status read.
        xfer(1'b0, 5'h11, 2'b00, 8'h05, 16, 1'b0, rv);
        pulse(8'h02);
        chk("R8 masked event", irq_od_en, 1'b0);
        pulse(8'h04);
        chk("R8 unmasked event", irq_od_en, 1'b1);
        xfer(1'b0, 5'h10, 2'b00, 8'hFF, 16, 1'b0, rv);
        chk("R9 status write ignored", irq_od_en, 1'b1);
        xfer(1'b1, 5'h10, 2'b00, 8'h00, 14, 1'b0, rv);
        chk("R7 abort keeps irq", irq_od_en, 1'b1);
        xfer(1'b1, 5'h10, 2'b00, 8'h00, 16, 1'b0, rv);
        chk("R8 status value", rv, 8'h04);
        chk("R9 irq released", irq_od_en, 1'b0);
        xfer(1'b1, 5'h10, 2'b00, 8'h00, 16, 1'b0, rv);
        chk("R9 status cleared", rv, 8'h00);

        // R6: split mode reads and writes through the secondary pin.
        pulse(8'h01);
        chk("R8 second event", irq_od_en, 1'b1);
        xfer(1'b0, 5'h0F, 2'b00, 8'h01, 16, 1'b0, rv);
        xfer(1'b1, 5'h03, 2'b00, 8'h00, 16, 1'b1, rv);
        chk("R6 split read", rv, 8'hAA);
        xfer(1'b0, 5'h04, 2'b00, 8'h3C, 16, 1'b1, rv);
        xfer(1'b1, 5'h04, 2'b00, 8'h00, 16, 1'b1, rv);
        chk("R6 split write", rv, 8'h3C);

        // R10: software reset clears mode, status and storage.
        xfer(1'b0, 5'h0F, 2'b00, 8'h80, 16, 1'b1, rv);
        chk("R10 irq cleared", irq_od_en, 1'b0);
        xfer(1'b1, 5'h0F, 2'b00, 8'h00, 16, 1'b0, rv);
        chk("R10 ctrl cleared", rv, 8'h00);
        xfer(1'b1, 5'h03, 2'b00, 8'h00, 16, 1'b0, rv);
        chk("R10 reg cleared", rv, 8'h00);
        xfer(1'b1, 5'h11, 2'b00, 8'h00, 16, 1'b0, rv);
        chk("R10 mask cleared", rv, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule